// File: doc/BRIEF.md
# Idle-Qualified Nibble Serial Receiver

This block recovers 4-bit words from a single asynchronous serial line that carries no stop bit. It synchronises on line silence instead: the transmitter holds the line high for several bit times between words, and the receiver accepts a start bit only after it has seen an unbroken high stretch of a programmable length. The first falling edge after that arms a bit timer. The timer then samples four data bits near their centres, one bit time apart.

The serial input passes through a two-flop synchroniser. An optional inversion is applied after it, so all decoding sees the corrected polarity. An abort input marks that a reception cannot be trusted. A word in flight is then thrown away with an error pulse, and the receiver returns to waiting for a fresh idle stretch. A good word appears on the nibble output with a one-cycle valid strobe. The nibble output holds that value until the next good word arrives.

Top module: `nib_idle_rx`

## Requirements
- R1: During and after reset `valid_o` and `err_o` are 0 and `nib_o` is 0. The receiver starts in the idle-wait state.
- R2: A start bit is accepted only after `IDLE_CYC` consecutive clock edges on which the synchronised line is high. With `IDLE_CYC-1` such edges the following word is ignored: no valid and no error.
- R3: A synchronised low during the idle wait, even for one cycle, restarts the idle count from zero.
- R4: Once idle is qualified, the first low on the synchronised line is taken as the start bit. Count as edge 0 the rising edge that first registers the low start bit at `rx_i`. `valid_o` is then high only in the cycle after edge `2 + FIRST + 3*BIT_CYC`, where `FIRST = BIT_CYC + BIT_CYC/2`. Data bit k is sampled `FIRST + k*BIT_CYC` edges after edge 2.
- R5: The first data bit received goes to `nib_o[0]` and the fourth to `nib_o[3]`. `nib_o` changes only together with a valid pulse.
- R6: With `invert_i` = 1 the line is inverted before idle detection and sampling, so the idle level at `rx_i` is low. The same data is then recovered.
- R7: Each good word gives exactly one single-cycle `valid_o` pulse. `valid_o` and `err_o` are never high together.
- R8: `abort_i` high on any edge from the one after start detection through the fourth sample edge has three effects. `err_o` pulses for one cycle after that edge, no valid pulse follows, and the receiver returns to the idle wait. An abort on the fourth sample edge wins over that sample.
- R9: `abort_i` during the idle wait or while armed gives no error pulse. It returns the receiver to the idle wait with the idle count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line |
| invert_i | input | 1 | 1 inverts line polarity before decoding |
| abort_i | input | 1 | Interference flag; discards a word in flight |
| nib_o | output | 4 | Last good received nibble |
| valid_o | output | 1 | One-cycle strobe for a new nibble |
| err_o | output | 1 | One-cycle strobe for an aborted word |

## Verification
The bench probes the idle threshold at exactly `IDLE_CYC` and at one edge short, and it injects a single-cycle glitch into the idle stretch. A receiver with an off-by-one idle count would accept a word it should drop, and one that failed to restart the count would accept the word that follows the glitch. An asymmetric nibble shows a reversed bit order. The exact cycle of the valid pulse shows a missing synchroniser stage or a sample point shifted from the bit centre. Aborts are placed one edge before start detection, inside the data phase, and on the fourth sample edge itself. These cases catch a design that reports errors while merely armed, or that lets the last sample win over the abort.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [1:0] {
        S_IDLE_WAIT = 2'd0,
        S_ARMED     = 2'd1,
        S_DATA      = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic                     sample;
        logic                     last;
        logic                     fail;
        logic [$clog2(NIB_W)-1:0] idx;
    } rx_ctrl_t;

    function automatic int first_sample_cyc(input int bit_cyc);
        return bit_cyc + bit_cyc / 2;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nib_rx_sync.sv
module nib_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    input  logic invert_i,
    output logic line_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= raw_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= 1'b1;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign line_o = chain[STAGES-1] ^ invert_i;
endmodule

// File: rtl/nib_rx_fsm.sv
module nib_rx_fsm
    import nib_rx_pkg::*;
#(
    parameter int BIT_CYC  = 750,
    parameter int IDLE_CYC = 5 * BIT_CYC
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_i,
    input  logic     abort_i,
    output rx_ctrl_t ctrl_o
);
    localparam int FIRST = first_sample_cyc(BIT_CYC);
    localparam int CNT_W = $clog2(max_int(IDLE_CYC, FIRST) + 1);
    localparam int IDX_W = $clog2(NIB_W);

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic             at_sample;

    assign at_sample = (st == S_DATA) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE_WAIT;
            cnt <= '0;
            idx <= '0;
        end else begin
            case (st)
                S_IDLE_WAIT: begin
                    if (abort_i || !line_i) begin
                        cnt <= '0;
                    end else if (cnt == CNT_W'(IDLE_CYC - 1)) begin
                        st  <= S_ARMED;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ARMED: begin
                    if (abort_i) begin
                        st <= S_IDLE_WAIT;
                    end else if (!line_i) begin
                        st  <= S_DATA;
                        cnt <= CNT_W'(FIRST - 1);
                        idx <= '0;
                    end
                end
                S_DATA: begin
                    if (abort_i) begin
                        st  <= S_IDLE_WAIT;
                        cnt <= '0;
                    end else if (at_sample) begin
                        if (idx == IDX_W'(NIB_W - 1)) begin
                            st  <= S_IDLE_WAIT;
                            cnt <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                            cnt <= CNT_W'(BIT_CYC - 1);
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st  <= S_IDLE_WAIT;
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctrl_o.sample = at_sample && !abort_i;
        ctrl_o.last   = at_sample && !abort_i && (idx == IDX_W'(NIB_W - 1));
        ctrl_o.fail   = (st == S_DATA) && abort_i;
        ctrl_o.idx    = idx;
    end

    // R8: an abort in the data phase always returns to the idle wait
    p_abort_returns_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_DATA && abort_i) |=> (st == S_IDLE_WAIT));

    // R2: arming only from a qualified idle wait with the line high
    p_arm_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARMED && $past(st) != S_ARMED) |-> ($past(st) == S_IDLE_WAIT && $past(line_i)));

    // R9: an abort while armed never leads into the data phase
    p_armed_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_ARMED && abort_i) |=> (st == S_IDLE_WAIT));
endmodule

// File: rtl/nib_rx_assemble.sv
module nib_rx_assemble
    import nib_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  rx_ctrl_t         ctrl_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             valid_o,
    output logic             err_o
);
    logic [NIB_W-1:0] shreg;
    logic [NIB_W-1:0] merged;

    always_comb begin
        merged              = shreg;
        merged[ctrl_i.idx]  = line_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            nib_o   <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= ctrl_i.fail;
            if (ctrl_i.sample) shreg <= merged;
            if (ctrl_i.last) begin
                nib_o   <= merged;
                valid_o <= 1'b1;
            end
        end
    end

    // R7: strobes are exclusive and last a single cycle
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && err_o));
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R8: error strobe is a single cycle
    p_err_single_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> !err_o);
    // R5: the output word moves only with a valid strobe
    p_nib_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(nib_o) |-> valid_o);
endmodule

// File: rtl/nib_idle_rx.sv
module nib_idle_rx
    import nib_rx_pkg::*;
#(
    parameter int BIT_CYC     = 750,
    parameter int IDLE_CYC    = 5 * BIT_CYC,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_i,
    input  logic             invert_i,
    input  logic             abort_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             valid_o,
    output logic             err_o
);
    logic     line;
    rx_ctrl_t ctrl;

    nib_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_i    (rx_i),
        .invert_i (invert_i),
        .line_o   (line)
    );

    nib_rx_fsm #(.BIT_CYC(BIT_CYC), .IDLE_CYC(IDLE_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line),
        .abort_i (abort_i),
        .ctrl_o  (ctrl)
    );

    nib_rx_assemble u_asm (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line),
        .ctrl_i  (ctrl),
        .nib_o   (nib_o),
        .valid_o (valid_o),
        .err_o   (err_o)
    );
endmodule

// File: tb/nib_idle_rx_bench.sv
`timescale 1ns/1ps
module nib_idle_rx_bench;
    localparam int B     = 8;
    localparam int IDLE  = 5 * B;
    localparam int FIRST = B + B / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       invert_i = 1'b0;
    logic       abort_i = 1'b0;
    logic [3:0] nib_o;
    logic       valid_o;
    logic       err_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int exp_v = -1;
    int exp_e = -1;
    bit done = 0;

    nib_idle_rx #(.BIT_CYC(B), .IDLE_CYC(IDLE)) u_nib_idle_rx (
        .clk(clk), .rst(rst), .rx_i(rx_i), .invert_i(invert_i),
        .abort_i(abort_i), .nib_o(nib_o), .valid_o(valid_o), .err_o(err_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison of both strobes against the expected event cycles
    task automatic tick();
        @(negedge clk);
        chk(valid_o === (cyc == exp_v), "R4/R7 valid strobe timing", int'(valid_o), int'(cyc == exp_v));
        chk(err_o === (cyc == exp_e), "R8/R9 error strobe timing", int'(err_o), int'(cyc == exp_e));
    endtask

    task automatic drive(input bit lvl, input bit inv);
        rx_i = lvl ^ inv;
    endtask

    task automatic run(input logic [3:0] nib, input bit inv, input int idle_n,
                       input int glitch_at, input int abort_idle, input int abort_at,
                       input bit exp_ok, input bit exp_err, input string tag);
        int cs;
        exp_v = -1;
        exp_e = -1;
        invert_i = inv;
        abort_i = 1'b0;
        rst = 1'b1;
        drive(1'b0, inv);
        repeat (3) tick();
        rst = 1'b0;
        repeat (4) tick();
        for (int j = 0; j < idle_n; j++) begin
            drive(j != glitch_at, inv);
            abort_i = (j == abort_idle);
            tick();
        end
        cs = cyc;
        if (exp_ok)  exp_v = cs + 3 + FIRST + 3 * B;
        if (exp_err) exp_e = cs + abort_at + 1;
        for (int i = 0; i < 5 * B; i++) begin
            drive((i < B) ? 1'b0 : nib[i / B - 1], inv);
            abort_i = (i == abort_at);
            tick();
        end
        abort_i = 1'b0;
        drive(1'b1, inv);
        repeat (3 * B) tick();
        chk(nib_o === (exp_ok ? nib : 4'd0), {tag, " nibble value"}, int'(nib_o), int'(exp_ok ? nib : 4'd0));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk(valid_o === 1'b0 && err_o === 1'b0, "R1 strobes low in reset", int'({valid_o, err_o}), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(nib_o === 4'd0, "R1 nibble zero after reset", int'(nib_o), 0);
        // R2/R4/R5: exact idle threshold, asymmetric bit order
        run(4'b1011, 0, IDLE,     -1, -1, -1, 1, 0, "R2 R5 threshold");
        // R2: one edge short of the threshold
        run(4'b0110, 0, IDLE - 1, -1, -1, -1, 0, 0, "R2 short idle");
        // R3: single-cycle glitch restarts the idle count
        run(4'b0001, 0, IDLE + 4,  5, -1, -1, 0, 0, "R3 glitch");
        // R6: inverted polarity
        run(4'b1000, 1, IDLE + 2, -1, -1, -1, 1, 0, "R6 inverted");
        run(4'b0111, 1, IDLE,     -1, -1, -1, 1, 0, "R6 inverted threshold");
        // R8: abort mid-data and on the fourth sample edge
        run(4'b1101, 0, IDLE + 2, -1, -1, 10, 0, 1, "R8 mid-data abort");
        run(4'b0101, 0, IDLE + 2, -1, -1, 2 + FIRST + 3 * B, 0, 1, "R8 last-sample abort");
        // R9: abort while armed, abort during idle wait
        run(4'b1110, 0, IDLE + 2, -1, -1, 2, 0, 0, "R9 armed abort");
        run(4'b0011, 0, IDLE + 3, -1,  5, -1, 0, 0, "R9 idle abort");
        // R5/R7: all-ones and all-zeros words
        run(4'b1111, 0, IDLE + 1, -1, -1, -1, 1, 0, "R5 ones");
        run(4'b0000, 0, IDLE + 1, -1, -1, -1, 1, 0, "R5 zeros");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule